// File: doc/BRIEF.md
# Two-Table Byte Permute Unit

The unit builds a lookup table of 2N bytes by joining two N-byte vectors and fills every byte of an N-byte result by picking one table entry, chosen by a per-byte index. The vector length N is 16, 32 or 64 bytes, picked per operation. An index is reduced modulo 2N. Bit log2(N) of the index picks the table half, and the low log2(N) bits pick the byte within that half. Result bytes at and above the active length are zero.

Two forms share one datapath and give the same permutation. They differ only in which operand the result overwrites. In the index-overwrite form, the destination register holds the indices, the first source is the lower table half, and the second source is the upper half. In the table-overwrite form, the destination register is the lower table half, the first source holds the indices, and the second source is the upper half. A per-byte write mask chooses, for each byte, between the permuted byte and a fallback. In merge mode the fallback is the old destination byte: an old index byte in the first form, an old table byte in the second. In zeroing mode the fallback is zero.

Operations enter on a valid/ready handshake and leave one cycle later on a second valid/ready handshake. An operation is taken when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result and `out_valid` hold their values and no new operation is taken.

Top module: `dual_table_permute`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_vec` is all zero until the first operation is taken.
- R2: An operation taken at clock edge k appears on `out_vec` with `out_valid` high right after edge k+1's predecessor, that is, one register stage after acceptance.
- R3: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_vec` and `out_valid` hold their values.
- R4: With `form_sel`=0 (index-overwrite), byte i takes its index from byte i of `dst_vec`. Table entry k is byte k of `src1_vec` for k<N and byte k-N of `src2_vec` for k>=N.
- R5: With `form_sel`=1 (table-overwrite), byte i takes its index from byte i of `src1_vec`. Table entry k is byte k of `dst_vec` for k<N and byte k-N of `src2_vec` for k>=N.
- R6: Each index is taken modulo 2N, so index bits above bit log2(N) are ignored. For example, with N=16, index 0xFF selects upper-half byte 15 and index 0x2F selects lower-half byte 15.
- R7: `len_sel` encodes N: 0 gives 16, 1 gives 32, and both 2 and 3 give 64. Result bytes at positions N and above are zero whatever the mask and zero mode.
- R8: With `zero_mode`=0, a byte whose mask bit is 0 equals the same byte of `dst_vec`.
- R9: With `zero_mode`=1, a byte whose mask bit is 0 is zero.
- R10: Bit i of `wr_mask` governs result byte i. A 1 selects the permuted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| form_sel | input | 1 | 0 index-overwrite, 1 table-overwrite |
| len_sel | input | 2 | Vector length code (0:16 B, 1:32 B, 2/3:64 B) |
| zero_mode | input | 1 | 1 zeroes masked-off bytes, 0 keeps destination byte |
| wr_mask | input | 64 | Per-byte write mask |
| dst_vec | input | 512 | Current destination register value |
| src1_vec | input | 512 | First source operand |
| src2_vec | input | 512 | Second source operand (upper table half) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_vec | output | 512 | Result to write back to the destination |

## Verification
The bench targets the points where index reduction and the active length meet. An index such as 0xFF or 0x2F at 16 bytes must wrap into the correct half and byte. A design that reduced modulo N, or that read a fixed bit as the half select, would return the wrong half or a byte from beyond the table. It checks that merge falls back to the destination in both forms. A design that merged from the index source in the table-overwrite form would leak index bytes into the result. It also checks that bytes above a short length stay zero even when their mask bits are set, and that the reserved length code acts as 64 bytes. Finally, it holds `out_ready` low while a second operation waits. A stage that let new data overwrite a stalled result would change `out_vec` before the handshake completes.

// File: rtl/dtp_pkg.sv
package dtp_pkg;
  localparam int MAX_BYTES = 64;
  localparam int VEC_W     = MAX_BYTES * 8;
  localparam int OFF_W     = $clog2(MAX_BYTES);

  typedef enum logic [1:0] {
    LEN_16B = 2'd0,
    LEN_32B = 2'd1,
    LEN_64B = 2'd2,
    LEN_64X = 2'd3
  } len_e;

  typedef enum logic {
    FORM_IDX_OVR = 1'b0,
    FORM_TBL_OVR = 1'b1
  } form_e;

  // Lanes that lie inside the active vector length.
  function automatic logic [MAX_BYTES-1:0] lanes_on(len_e l);
    logic [MAX_BYTES-1:0] m;
    case (l)
      LEN_16B: m = {{(MAX_BYTES-16){1'b0}}, {16{1'b1}}};
      LEN_32B: m = {{(MAX_BYTES-32){1'b0}}, {32{1'b1}}};
      default: m = {MAX_BYTES{1'b1}};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/dtp_route.sv
module dtp_route #(
  parameter int W = dtp_pkg::VEC_W
) (
  input  dtp_pkg::form_e form,
  input  logic [W-1:0]   dst_v,
  input  logic [W-1:0]   s1_v,
  output logic [W-1:0]   idx_v,
  output logic [W-1:0]   low_v
);
  // Pick which operand supplies indices and which forms the lower table half.
  always_comb begin
    if (form == dtp_pkg::FORM_TBL_OVR) begin
      idx_v = s1_v;
      low_v = dst_v;
    end else begin
      idx_v = dst_v;
      low_v = s1_v;
    end
  end
endmodule

// File: rtl/dtp_lane.sv
module dtp_lane #(
  parameter int NB = dtp_pkg::MAX_BYTES
) (
  input  logic [7:0]      idx_b,
  input  logic [NB*8-1:0] low_v,
  input  logic [NB*8-1:0] high_v,
  input  dtp_pkg::len_e   len,
  input  logic            on,
  input  logic            sel,
  input  logic            zero,
  input  logic [7:0]      keep_b,
  output logic [7:0]      res_b
);
  localparam int OW = $clog2(NB);

  logic          half;
  logic [OW-1:0] off;
  logic [7:0]    picked;

  // Half select is bit log2(N); byte offset is the bits below it.
  always_comb begin
    case (len)
      dtp_pkg::LEN_16B: begin half = idx_b[4]; off = OW'(idx_b[3:0]); end
      dtp_pkg::LEN_32B: begin half = idx_b[5]; off = OW'(idx_b[4:0]); end
      default:          begin half = idx_b[6]; off = OW'(idx_b[5:0]); end
    endcase
    picked = half ? high_v[{off, 3'b000} +: 8] : low_v[{off, 3'b000} +: 8];
    if (!on)       res_b = 8'h00;
    else if (sel)  res_b = picked;
    else if (zero) res_b = 8'h00;
    else           res_b = keep_b;
  end
endmodule

// File: rtl/dtp_stage.sv
module dtp_stage #(
  parameter int W = dtp_pkg::VEC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) q <= d;
    end
  end
endmodule

// File: rtl/dual_table_permute.sv
module dual_table_permute (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic                            form_sel,
  input  logic [1:0]                      len_sel,
  input  logic                            zero_mode,
  input  logic [dtp_pkg::MAX_BYTES-1:0]   wr_mask,
  input  logic [dtp_pkg::VEC_W-1:0]       dst_vec,
  input  logic [dtp_pkg::VEC_W-1:0]       src1_vec,
  input  logic [dtp_pkg::VEC_W-1:0]       src2_vec,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [dtp_pkg::VEC_W-1:0]       out_vec
);
  localparam int NB = dtp_pkg::MAX_BYTES;
  localparam int W  = dtp_pkg::VEC_W;

  dtp_pkg::len_e  len;
  dtp_pkg::form_e form;
  logic [W-1:0]   idx_v;
  logic [W-1:0]   low_v;
  logic [NB-1:0]  on_v;
  logic [W-1:0]   result;

  assign len  = dtp_pkg::len_e'(len_sel);
  assign form = dtp_pkg::form_e'(form_sel);
  assign on_v = dtp_pkg::lanes_on(len);

  dtp_route #(.W(W)) u_route (
    .form  (form),
    .dst_v (dst_vec),
    .s1_v  (src1_vec),
    .idx_v (idx_v),
    .low_v (low_v)
  );

  for (genvar i = 0; i < NB; i++) begin : g_lane
    dtp_lane #(.NB(NB)) u_lane (
      .idx_b  (idx_v[i*8 +: 8]),
      .low_v  (low_v),
      .high_v (src2_vec),
      .len    (len),
      .on     (on_v[i]),
      .sel    (wr_mask[i]),
      .zero   (zero_mode),
      .keep_b (dst_vec[i*8 +: 8]),
      .res_b  (result[i*8 +: 8])
    );
  end

  dtp_stage #(.W(W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d         (result),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (out_vec)
  );
endmodule

// File: rtl/dual_table_permute_chk.sv
module dual_table_permute_chk (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic                          in_ready,
  input logic [1:0]                    len_sel,
  input logic                          zero_mode,
  input logic [dtp_pkg::MAX_BYTES-1:0] wr_mask,
  input logic [dtp_pkg::VEC_W-1:0]     dst_vec,
  input logic                          out_valid,
  input logic                          out_ready,
  input logic [dtp_pkg::VEC_W-1:0]     out_vec
);
  localparam int W = dtp_pkg::VEC_W;

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R2
  one_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vec));

  // R3
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R7
  short_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && len_sel == 2'd0 |=> out_vec[W-1:128] == '0);

  // R8
  merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !zero_mode && wr_mask == '0 && len_sel[1]
    |=> out_vec == $past(dst_vec));

  // R9
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && zero_mode && wr_mask == '0 |=> out_vec == '0);
endmodule

bind dual_table_permute dual_table_permute_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .len_sel   (len_sel),
  .zero_mode (zero_mode),
  .wr_mask   (wr_mask),
  .dst_vec   (dst_vec),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_vec   (out_vec)
);

// File: tb/dual_table_permute_bench.sv
module dual_table_permute_bench;
  localparam int NB = 64;
  localparam int W  = NB * 8;
  localparam int NV = 8;

  // {form, len[1:0], zero, mask[63:0], seed[7:0]}
  localparam logic [75:0] VECS [0:NV-1] = '{
    {1'b0, 2'd2, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd3},
    {1'b1, 2'd2, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd5},
    {1'b0, 2'd0, 1'b0, 64'h5555_5555_5555_5555, 8'd7},
    {1'b1, 2'd1, 1'b1, 64'h00FF_00FF_00FF_00FF, 8'd9},
    {1'b1, 2'd0, 1'b0, 64'hF0F0_F0F0_F0F0_F0F0, 8'd11},
    {1'b0, 2'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 8'd13},
    {1'b0, 2'd3, 1'b0, 64'h0123_4567_89AB_CDEF, 8'd17},
    {1'b1, 2'd2, 1'b1, 64'hFFFF_0000_FFFF_0000, 8'd19}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          form_sel = 1'b0;
  logic [1:0]    len_sel = 2'd0;
  logic          zero_mode = 1'b0;
  logic [NB-1:0] wr_mask = '0;
  logic [W-1:0]  dst_vec = '0;
  logic [W-1:0]  src1_vec = '0;
  logic [W-1:0]  src2_vec = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [W-1:0]  out_vec;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dual_table_permute u_dual_table_permute (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .form_sel(form_sel), .len_sel(len_sel), .zero_mode(zero_mode),
    .wr_mask(wr_mask), .dst_vec(dst_vec), .src1_vec(src1_vec),
    .src2_vec(src2_vec), .out_valid(out_valid), .out_ready(out_ready),
    .out_vec(out_vec)
  );

  function automatic logic [W-1:0] mk(int seed, int salt);
    logic [W-1:0] r;
    for (int i = 0; i < NB; i++) r[i*8 +: 8] = 8'(seed * 29 + i * 11 + salt + (i >> 2) * 7);
    return r;
  endfunction

  // Reference written from the requirements: concatenated table, modulo 2N.
  function automatic logic [W-1:0] model(logic f, logic [1:0] l, logic z, logic [NB-1:0] m,
                                         logic [W-1:0] d, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] r;
    logic [2*W-1:0] tbl;
    int n;
    int k;
    n = (l == 2'd0) ? 16 : (l == 2'd1) ? 32 : 64;
    tbl = '0;
    for (int j = 0; j < n; j++) begin
      tbl[j*8 +: 8]     = f ? d[j*8 +: 8] : a[j*8 +: 8];
      tbl[(n+j)*8 +: 8] = b[j*8 +: 8];
    end
    r = '0;
    for (int i = 0; i < n; i++) begin
      k = int'(f ? a[i*8 +: 8] : d[i*8 +: 8]) % (2 * n);
      if (m[i])      r[i*8 +: 8] = tbl[k*8 +: 8];
      else if (!z)   r[i*8 +: 8] = d[i*8 +: 8];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Drive one operation at a falling edge, sample one cycle later.
  task automatic send(logic f, logic [1:0] l, logic z, logic [NB-1:0] m,
                      logic [W-1:0] d, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    form_sel = f; len_sel = l; zero_mode = z; wr_mask = m;
    dst_vec = d; src1_vec = a; src2_vec = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] d, a, b, e, ra;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", W'(out_valid), W'(0));
    check("R1 out_vec", out_vec, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after release", W'(out_valid), W'(0));
    check("R3 in_ready idle", W'(in_ready), W'(1));

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic f; logic [1:0] l; logic z; logic [NB-1:0] m; int s;
      {f, l, z, m} = VECS[v][75:8];
      s = int'(VECS[v][7:0]);
      d = mk(s, 1); a = mk(s, 77); b = mk(s, 151);
      e = model(f, l, z, m, d, a, b);
      send(f, l, z, m, d, a, b);
      check(f ? "R5 table form R8 R9 R10" : "R4 index form R8 R9 R10", out_vec, e);
      check("R2 valid", W'(out_valid), W'(1));
      if (l == 2'd0) check("R7 upper zero", {out_vec[W-1:128], 128'h0}, '0);
    end

    // R6 wrap at 16 bytes, index-overwrite form
    a = mk(41, 3); b = mk(43, 9);
    d = '0; d[7:0] = 8'hFF; d[15:8] = 8'h10; d[23:16] = 8'h2F;
    send(1'b0, 2'd0, 1'b0, 64'h7, d, a, b);
    check("R6 idx FF", W'(out_vec[7:0]),   W'(b[15*8 +: 8]));
    check("R6 idx 10", W'(out_vec[15:8]),  W'(b[7:0]));
    check("R6 idx 2F", W'(out_vec[23:16]), W'(a[15*8 +: 8]));

    // R7 short length with full mask: upper stays zero
    d = mk(55, 4); a = mk(57, 8); b = mk(59, 12);
    send(1'b1, 2'd1, 1'b0, '1, d, a, b);
    check("R7 32B upper", {out_vec[W-1:256], 256'h0}, '0);

    // R8 merge in table-overwrite form keeps destination, not indices
    send(1'b1, 2'd2, 1'b0, '0, d, a, b);
    check("R8 merge keeps dst", out_vec, d);

    // R10 single lane selected
    e = d; e[9*8 +: 8] = model(1'b0, 2'd2, 1'b0, '1, d, a, b) >> (9*8);
    send(1'b0, 2'd2, 1'b0, 64'h200, d, a, b);
    check("R10 single lane", out_vec, e);

    // R3 back-pressure: result held, second op waits
    @(negedge clk);
    out_ready = 1'b0;
    ra = model(1'b0, 2'd2, 1'b1, '1, d, a, b);
    form_sel = 1'b0; len_sel = 2'd2; zero_mode = 1'b1; wr_mask = '1;
    dst_vec = d; src1_vec = a; src2_vec = b; in_valid = 1'b1;
    @(negedge clk);
    check("R3 first result", out_vec, ra);
    check("R3 ready low", W'(in_ready), W'(0));
    e = model(1'b1, 2'd0, 1'b0, '1, b, d, a);
    dst_vec = b; src1_vec = d; src2_vec = a; form_sel = 1'b1; len_sel = 2'd0; zero_mode = 1'b0;
    @(negedge clk);
    check("R3 held", out_vec, ra);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 second result", out_vec, e);

    summary();
    $finish;
  end
endmodule